// File: doc/BRIEF.md
# Word-Counted Output DMA Writer

This block takes 32-bit words from one output stream of a video decoder and writes them to main memory in bursts. A decoder uses two copies side by side: one takes macroblock header words and the other takes run-length coefficient words. Each copy has its own destination address and its own length.

The host loads a byte address and a length, counted in 32-bit words. Words enter through a valid/ready push port and collect in a 16-word (64-byte) buffer. When the buffer is full, the block sends the words to memory as one burst. While it sends the burst it refuses new words. After each burst the address moves forward by the bytes written, and the remaining count goes down by the number of words written.

The last part of a job can be shorter than 16 words. In that case the burst starts as soon as the remaining words are buffered. When the count reaches zero, a done flag rises and input stays blocked until the host loads a new job.

Top module: `owd_writer`

## Requirements
- R1: While reset is active and in the first cycle after release, `in_ready`, `wr_valid` and `done` are low and `stat_remain` is zero.
- R2: A `cfg_we` pulse in a cycle with no burst in progress loads `cfg_addr` and `cfg_words`, clears `done` and discards buffered words. The loaded values show on `stat_addr`/`stat_remain` in the next cycle. A `cfg_we` pulse during a burst has no effect.
- R3: `in_ready` is high only when no burst is in progress, `cfg_we` is low, and fewer than min(`stat_remain`, 16) words are buffered. A word is taken on a cycle with `in_valid` and `in_ready` both high.
- R4: When the 16th word is taken, a burst of 16 beats follows. The beats carry the words in arrival order, `wr_addr` equals the current `stat_addr`, `wr_len` is 16, and `wr_last` is high only on the 16th beat.
- R5: When `stat_remain` is below 16, the burst starts once that many words are buffered, and `wr_len` equals that count.
- R6: When the last beat of a burst is accepted, `stat_addr` grows by 4 × `wr_len` (64 for a full burst) and `stat_remain` drops by `wr_len`.
- R7: `done` rises in the cycle after the final beat of the burst that brings `stat_remain` to zero. It stays high until the next accepted `cfg_we`.
- R8: `in_ready` is low for the whole of every burst, and low whenever `stat_remain` is zero.
- R9: A beat is accepted on a cycle with `wr_valid` and `wr_ready` both high. While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_len`, `wr_data` and `wr_last` hold their values.
- R10: Loading a count of zero leaves `in_ready` and `done` low, and no burst is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host load strobe for address and count |
| cfg_addr | input | 32 | Destination byte address to load |
| cfg_words | input | 16 | Transfer length to load, in 32-bit words |
| in_valid | input | 1 | Push word valid |
| in_data | input | 32 | Push word |
| in_ready | output | 1 | Push word accepted when high with in_valid |
| wr_valid | output | 1 | Burst beat valid |
| wr_addr | output | 32 | Burst base byte address |
| wr_len | output | 5 | Burst length in words |
| wr_data | output | 32 | Beat data |
| wr_last | output | 1 | Final beat of the burst |
| wr_ready | input | 1 | Memory accepts the current beat |
| done | output | 1 | Programmed length fully written |
| stat_addr | output | 32 | Next destination byte address |
| stat_remain | output | 16 | Words still to be written |

## Verification
The assertions assume that the host pulses `cfg_we` only for one cycle at a time. They also assume the memory side never takes back a beat it has accepted, so every beat is complete when `wr_valid` and `wr_ready` are high at a clock edge. The stimulus follows these rules. The host loads a job only when the block is idle or done, except for one deliberate load during a burst, which tests that such a load has no effect. The memory model changes `wr_ready` only between clock edges, with a repeating stall pattern, and every beat it accepts goes straight to the scoreboard.

// File: rtl/owd_pkg.sv
package owd_pkg;
  typedef enum logic [0:0] {
    OWD_FILL  = 1'b0,
    OWD_FLUSH = 1'b1
  } owd_state_e;
endpackage

// File: rtl/owd_rst_sync.sv
module owd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/owd_buf.sv
module owd_buf #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [DEPTH-1:0][WORD_W-1:0] ent_flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [WORD_W-1:0] ent_q;
    logic              ent_en;
    assign ent_en = wr_en && (wr_idx == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (ent_en) ent_q <= wr_word;
    end
    assign ent_flat[i] = ent_q;
  end

  assign rd_word = ent_flat[rd_idx];
endmodule

// File: rtl/owd_ctrl.sv
module owd_ctrl
  import owd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int WORD_W    = 32,
  parameter int BUF_WORDS = 16,
  localparam int PTR_W    = $clog2(BUF_WORDS),
  localparam int LEN_W    = $clog2(BUF_WORDS + 1),
  localparam int BYTE_SH  = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_words,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              buf_we,
  output logic [PTR_W-1:0]  buf_widx,
  output logic [PTR_W-1:0]  buf_ridx,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_len,
  output logic              wr_last,
  input  logic              wr_ready,
  output logic              done,
  output logic [ADDR_W-1:0] stat_addr,
  output logic [CNT_W-1:0]  stat_remain
);
  owd_state_e        state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  remain_q, remain_n;
  logic [LEN_W-1:0]  fill_q, fill_n;
  logic [PTR_W-1:0]  rd_q, rd_n;
  logic              done_q, done_n;
  logic              state_en, addr_en, remain_en, fill_en, rd_en, done_en;

  logic [LEN_W-1:0]  target;
  logic              accept, beat, beat_last, flushing;

  always_comb begin
    if (remain_q >= CNT_W'(BUF_WORDS)) target = LEN_W'(BUF_WORDS);
    else                               target = remain_q[LEN_W-1:0];
  end

  assign flushing  = (state_q == OWD_FLUSH);
  assign in_ready  = !flushing && !cfg_we && (fill_q < target);
  assign accept    = in_valid && in_ready;
  assign beat      = flushing && wr_ready;
  assign wr_last   = flushing && ((LEN_W'(rd_q) + LEN_W'(1)) == fill_q);
  assign beat_last = beat && wr_last;

  // next-state logic
  always_comb begin
    state_n  = state_q;
    addr_n   = addr_q;
    remain_n = remain_q;
    fill_n   = fill_q;
    rd_n     = rd_q;
    done_n   = done_q;
    if (!flushing) begin
      if (cfg_we) begin
        addr_n   = cfg_addr;
        remain_n = cfg_words;
        fill_n   = '0;
        done_n   = 1'b0;
      end else if (accept) begin
        fill_n = fill_q + LEN_W'(1);
        rd_n   = '0;
        if (fill_n == target) state_n = OWD_FLUSH;
      end
    end else if (beat) begin
      rd_n = rd_q + PTR_W'(1);
      if (beat_last) begin
        state_n  = OWD_FILL;
        fill_n   = '0;
        rd_n     = '0;
        addr_n   = addr_q + (ADDR_W'(fill_q) << BYTE_SH);
        remain_n = remain_q - CNT_W'(fill_q);
        if (remain_q == CNT_W'(fill_q)) done_n = 1'b1;
      end
    end
  end

  assign state_en  = (state_n != state_q);
  assign addr_en   = (!flushing && cfg_we) || beat_last;
  assign remain_en = addr_en;
  assign fill_en   = (!flushing && (cfg_we || accept)) || beat_last;
  assign rd_en     = beat || accept;
  assign done_en   = (!flushing && cfg_we) || beat_last;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= OWD_FILL;
      addr_q   <= '0;
      remain_q <= '0;
      fill_q   <= '0;
      rd_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      if (state_en)  state_q  <= state_n;
      if (addr_en)   addr_q   <= addr_n;
      if (remain_en) remain_q <= remain_n;
      if (fill_en)   fill_q   <= fill_n;
      if (rd_en)     rd_q     <= rd_n;
      if (done_en)   done_q   <= done_n;
    end
  end

  assign buf_we      = accept;
  assign buf_widx    = fill_q[PTR_W-1:0];
  assign buf_ridx    = rd_q;
  assign wr_valid    = flushing;
  assign wr_addr     = addr_q;
  assign wr_len      = fill_q;
  assign done        = done_q;
  assign stat_addr   = addr_q;
  assign stat_remain = remain_q;

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= LEN_W'(BUF_WORDS));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_len) && $stable(rd_q)));

  // R6
  remain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_last) |=> (stat_remain == $past(stat_remain) - CNT_W'($past(wr_len))));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_last) |=> (stat_addr == $past(stat_addr) + (ADDR_W'($past(wr_len)) << BYTE_SH)));

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(wr_valid && wr_ready && wr_last) && (stat_remain == '0)));

  // R2
  flush_cfg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !(wr_ready && wr_last)) |=> ($stable(stat_addr) && $stable(stat_remain) && wr_valid));
endmodule

// File: rtl/owd_writer.sv
module owd_writer #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int WORD_W    = 32,
  parameter int BUF_WORDS = 16,
  localparam int PTR_W    = $clog2(BUF_WORDS),
  localparam int LEN_W    = $clog2(BUF_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_words,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_len,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_last,
  input  logic              wr_ready,
  output logic              done,
  output logic [ADDR_W-1:0] stat_addr,
  output logic [CNT_W-1:0]  stat_remain
);
  logic             rst_sync_n;
  logic             buf_we;
  logic [PTR_W-1:0] buf_widx, buf_ridx;

  owd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  owd_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_W(WORD_W), .BUF_WORDS(BUF_WORDS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_words   (cfg_words),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .buf_we      (buf_we),
    .buf_widx    (buf_widx),
    .buf_ridx    (buf_ridx),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_len      (wr_len),
    .wr_last     (wr_last),
    .wr_ready    (wr_ready),
    .done        (done),
    .stat_addr   (stat_addr),
    .stat_remain (stat_remain)
  );

  owd_buf #(.WORD_W(WORD_W), .DEPTH(BUF_WORDS)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (buf_widx),
    .wr_word (in_data),
    .rd_idx  (buf_ridx),
    .rd_word (wr_data)
  );

  // R8
  ready_flush_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_valid |-> !in_ready);

  // R8
  ready_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_remain == '0) |-> !in_ready);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_valid && !wr_ready) |=> $stable(wr_data));
endmodule

// File: tb/owd_writer_bench.sv
module owd_writer_bench;
  typedef struct packed {
    logic [31:0] data;
    logic [31:0] addr;
    logic [4:0]  len;
    logic        last;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_addr;
  logic [15:0] cfg_words;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [4:0]  wr_len;
  logic [31:0] wr_data;
  logic        wr_last;
  logic        wr_ready;
  logic        done;
  logic [31:0] stat_addr;
  logic [15:0] stat_remain;

  int compared   = 0;
  int mismatched = 0;
  int stall_mode = 0;
  int cyc        = 0;
  beat_t exp_q[$];

  always #5 clk = ~clk;

  owd_writer u_owd_writer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_words(cfg_words), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_len(wr_len), .wr_data(wr_data), .wr_last(wr_last),
    .wr_ready(wr_ready), .done(done), .stat_addr(stat_addr),
    .stat_remain(stat_remain)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model and monitor: drives wr_ready between edges, scores accepted beats
  initial begin
    wr_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      wr_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      #2;
      if (wr_valid) check(!in_ready, "R8", "in_ready during burst", 32'(in_ready), 32'd0);
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected beat", wr_data, 32'd0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check(wr_data == e.data, "R4", "beat data", wr_data, e.data);
          check(wr_addr == e.addr, "R6", "burst address", wr_addr, e.addr);
          check(wr_len == e.len, "R5", "burst length", 32'(wr_len), 32'(e.len));
          check(wr_last == e.last, "R4", "last flag", 32'(wr_last), 32'(e.last));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic program_job(input logic [31:0] base, input logic [15:0] cnt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = base; cfg_words = cnt;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check(stat_addr == base, "R2", "loaded address", stat_addr, base);
    check(stat_remain == cnt, "R2", "loaded count", 32'(stat_remain), 32'(cnt));
    check(!done, "R2", "done cleared", 32'(done), 32'd0);
  endtask

  task automatic push_word(input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic run_job(input logic [31:0] base, input int cnt, input int stall,
                         input int gaps, input bit poke, input logic [7:0] tag);
    beat_t e;
    stall_mode = stall;
    program_job(base, 16'(cnt));
    for (int i = 0; i < cnt; i++) begin
      e.data = {tag, 24'(i * 7 + 3)};
      e.addr = base + 32'((i / 16) * 64);
      e.len  = ((cnt - (i / 16) * 16) >= 16) ? 5'd16 : 5'(cnt - (i / 16) * 16);
      e.last = ((i % 16) == 15) || (i == cnt - 1);
      exp_q.push_back(e);
      push_word(e.data);
      if (gaps != 0 && (i % 5) == 4) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      if (poke && i == 15) begin
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(wr_valid, "R4", "burst starts after 16th word", 32'(wr_valid), 32'd1);
        // R2: load attempt during a burst must be ignored
        cfg_we = 1'b1; cfg_addr = 32'hDEAD_0000; cfg_words = 16'd3;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int w = 0; w < 400 && !done; w++) @(negedge clk);
    #3;
    check(done, "R7", "done after final burst", 32'(done), 32'd1);
    check(exp_q.size() == 0, "R4", "all beats written", 32'(exp_q.size()), 32'd0);
    check(stat_addr == base + 32'(cnt * 4), "R6", "final address", stat_addr, base + 32'(cnt * 4));
    check(stat_remain == 16'd0, "R6", "final count", 32'(stat_remain), 32'd0);
    // R8: zero remaining blocks input even with valid held
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'hBAD0_BAD0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(!in_ready, "R8", "ready low at zero count", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    #1;
    check(done, "R7", "done holds", 32'(done), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_words = '0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!in_ready && !wr_valid && !done, "R1", "outputs in reset",
          {29'd0, in_ready, wr_valid, done}, 32'd0);
    check(stat_remain == 16'd0, "R1", "count in reset", 32'(stat_remain), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!in_ready && !wr_valid && !done, "R1", "outputs after release",
          {29'd0, in_ready, wr_valid, done}, 32'd0);

    run_job(32'h0000_1000, 16, 0, 0, 1'b0, 8'hA1);   // R4 exact full burst
    run_job(32'h0000_2000, 40, 1, 1, 1'b0, 8'hB2);   // R5 two full plus tail, stalls
    run_job(32'h0000_3000, 5, 1, 0, 1'b0, 8'hC3);    // R5 short job only
    run_job(32'h0001_0000, 33, 1, 0, 1'b1, 8'hD4);   // R2 ignored load mid-burst, R9 stalls

    // R10: zero count load
    program_job(32'h0000_4000, 16'd0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'h1234_5678;
    #1;
    check(!in_ready, "R10", "ready low on zero load", 32'(in_ready), 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    #3;
    check(!done, "R10", "done low on zero load", 32'(done), 32'd0);
    check(exp_q.size() == 0, "R10", "no burst on zero load", 32'(exp_q.size()), 32'd0);

    // R3: ready returns after reprogram
    program_job(32'h0000_5000, 16'd2);
    #1;
    check(in_ready, "R3", "ready after load", 32'(in_ready), 32'd1);
    run_job(32'h0000_6000, 2, 0, 0, 1'b0, 8'hE5);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule